// File: doc/BRIEF.md
# DRAM Command and Refresh Sequencer

This block is the control path of a DDR3-style memory controller. A client hands it one read or write request at a time (bank, row and column) through a valid/ready pair. The block turns each accepted request into a fixed closed-page command sequence on the active-low command pins. It first opens the row with an activate, then issues the column read or write after the row-to-column gap, then closes the bank with a precharge. The next access is allowed only after the precharge recovery gap.

A free-running timer requests an all-bank refresh once per refresh interval. A pending refresh takes priority over client traffic. Any access already in flight runs to its precharge, then the refresh command is sent. The client is held off until the refresh busy time has elapsed.

All intervals are counted in controller clock cycles. The refresh interval and refresh busy time are given in picoseconds and converted through a clock-period parameter. No request is taken before the power-on initialization phase reports completion.

Top module: `memcmd_sequencer`

## Requirements
- R1: Until `init_done_i` is high, `req_ready_o` stays low. On every cycle with no command, the pins {CSN,RASN,CASN,WEN} are 1111 and the address and bank buses are zero. `req_ready_o` rises one cycle after `init_done_i` is first seen high.
- R2: A request accepted on a rising edge (valid and ready both high) produces an activate {0,0,1,1} in the next cycle. The activate carries the request row on the address bus and the request bank on the bank bus.
- R3: The column command follows exactly TRCD_CYC cycles after the activate, with NOPs in between. It is a write {0,1,0,0} or a read {0,1,0,1}, carries the column on the address bus and the same bank.
- R4: The cycle after the column command carries a precharge {0,1,0} with CSN low ({0,0,1,0}), the accessed bank and a zero address bus.
- R5: `req_ready_o` stays low from acceptance until TRP_CYC cycles after the precharge and rises in that cycle when no refresh is pending. With a request held valid, the next activate comes exactly TRP_CYC+1 cycles after the precharge.
- R6: A refresh is {0,0,0,1} with zero address and bank. With REFI_CYC = floor(REFI_PS/CLK_PS), consecutive refreshes on an idle client are exactly REFI_CYC cycles apart. The refresh grid does not drift when a refresh is delayed.
- R7: With TRFC_CYC = ceil(TRFC_PS/CLK_PS), `req_ready_o` is low for TRFC_CYC cycles starting at the refresh. No activate, read or write appears in that window. A request held valid produces its activate exactly TRFC_CYC+1 cycles after the refresh.
- R8: Once a refresh is due, `req_ready_o` is low even when the sequencer is idle and a request is waiting. The refresh is sent before any new activate.
- R9: When a refresh falls due during an access, the access completes through its precharge before the refresh. The refresh comes at least TRP_CYC+1 cycles after that precharge and no later than TRCD_CYC+TRP_CYC+2 cycles after its grid point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_done_i | input | 1 | Initialization phase finished |
| req_valid_i | input | 1 | Client request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BANK_W (3) | Request bank |
| req_row_i | input | ADDR_W (16) | Request row |
| req_col_i | input | ADDR_W (16) | Request column |
| req_ready_o | output | 1 | Request may be accepted this cycle |
| cmd_csn_o | output | 1 | Chip select, active low |
| cmd_rasn_o | output | 1 | Row strobe, active low |
| cmd_casn_o | output | 1 | Column strobe, active low |
| cmd_wen_o | output | 1 | Write enable, active low |
| cmd_addr_o | output | ADDR_W (16) | Address bus |
| cmd_bank_o | output | BANK_W (3) | Bank address bus |

## Verification
Single writes and reads to distinct banks and rows show that the column opcode follows the request direction and that row, column and bank each land on the bus in the right command slot. A request held valid across two accesses measures the precharge-to-activate gap rather than the ready timing. A request raised in the cycle before a due refresh separates refresh priority from ordinary idle acceptance. A continuous request stream across a refresh point distinguishes "finish the open access, then refresh" from both pre-empting the access and losing the refresh grid.

// File: rtl/memcmd_pkg.sv
package memcmd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF
    } cmd_e;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_RCD,
        ST_COL,
        ST_RP,
        ST_RFC
    } seq_state_e;

    // pin order {csn, rasn, casn, wen}
    localparam logic [3:0] PINS_NOP = 4'b1111;
    localparam logic [3:0] PINS_ACT = 4'b0011;
    localparam logic [3:0] PINS_RD  = 4'b0101;
    localparam logic [3:0] PINS_WR  = 4'b0100;
    localparam logic [3:0] PINS_PRE = 4'b0010;
    localparam logic [3:0] PINS_REF = 4'b0001;

    function automatic int unsigned div_ceil(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/memcmd_pin_encoder.sv
module memcmd_pin_encoder
    import memcmd_pkg::*;
(
    input  cmd_e       cmd_i,
    output logic [3:0] pins_o
);

    always_comb begin
        case (cmd_i)
            CMD_ACT: pins_o = PINS_ACT;
            CMD_RD:  pins_o = PINS_RD;
            CMD_WR:  pins_o = PINS_WR;
            CMD_PRE: pins_o = PINS_PRE;
            CMD_REF: pins_o = PINS_REF;
            default: pins_o = PINS_NOP;
        endcase
    end

endmodule

// File: rtl/memcmd_refresh_timer.sv
module memcmd_refresh_timer #(
    parameter int unsigned PERIOD_CYC = 976
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clear_i,
    output logic due_o
);

    localparam int unsigned W = (PERIOD_CYC < 2) ? 1 : $clog2(PERIOD_CYC);
    localparam logic [W-1:0] LAST = W'(PERIOD_CYC - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         due;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.due = tmr_q.due & ~clear_i;
        if (run_i) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.cnt = '0;
                tmr_d.due = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign due_o = tmr_q.due;

    // R6: the due flag is only raised by a counter wrap while running
    p_due_from_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(due_o) |-> $past(run_i));

endmodule

// File: rtl/memcmd_wait_counter.sv
module memcmd_wait_counter #(
    parameter int unsigned W = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = value_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/memcmd_sequencer.sv
module memcmd_sequencer
    import memcmd_pkg::*;
#(
    parameter int unsigned CLK_PS   = 8000,
    parameter int unsigned REFI_PS  = 7812500,
    parameter int unsigned TRFC_PS  = 350000,
    parameter int unsigned TRCD_CYC = 2,
    parameter int unsigned TRP_CYC  = 2,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned BANK_W   = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              init_done_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ADDR_W-1:0] req_row_i,
    input  logic [ADDR_W-1:0] req_col_i,
    output logic              req_ready_o,
    output logic              cmd_csn_o,
    output logic              cmd_rasn_o,
    output logic              cmd_casn_o,
    output logic              cmd_wen_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [BANK_W-1:0] cmd_bank_o
);

    localparam int unsigned REFI_CYC = REFI_PS / CLK_PS;
    localparam int unsigned TRFC_CYC = div_ceil(TRFC_PS, CLK_PS);
    localparam int unsigned MAX_A    = (TRCD_CYC > TRP_CYC) ? TRCD_CYC : TRP_CYC;
    localparam int unsigned MAX_WAIT = (TRFC_CYC > MAX_A) ? TRFC_CYC : MAX_A;
    localparam int unsigned WAIT_W   = $clog2(MAX_WAIT + 1);

    localparam logic [WAIT_W-1:0] LD_RCD = WAIT_W'(TRCD_CYC - 1);
    localparam logic [WAIT_W-1:0] LD_RP  = WAIT_W'(TRP_CYC - 1);
    localparam logic [WAIT_W-1:0] LD_RFC = WAIT_W'(TRFC_CYC - 1);

    typedef struct packed {
        seq_state_e        st;
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] ba;
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] col;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              ref_due;
    logic              ref_clear;
    logic              wait_load;
    logic [WAIT_W-1:0] wait_value;
    logic              wait_zero;
    logic [3:0]        pins;

    memcmd_refresh_timer #(
        .PERIOD_CYC (REFI_CYC)
    ) u_refresh_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (seq_q.st != ST_INIT),
        .clear_i (ref_clear),
        .due_o   (ref_due)
    );

    memcmd_wait_counter #(
        .W (WAIT_W)
    ) u_wait_counter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (wait_load),
        .value_i (wait_value),
        .zero_o  (wait_zero)
    );

    memcmd_pin_encoder u_pin_encoder (
        .cmd_i  (seq_q.cmd),
        .pins_o (pins)
    );

    assign req_ready_o = (seq_q.st == ST_IDLE) && !ref_due;

    always_comb begin
        seq_d      = seq_q;
        seq_d.cmd  = CMD_NOP;
        seq_d.addr = '0;
        seq_d.ba   = '0;
        wait_load  = 1'b0;
        wait_value = '0;
        ref_clear  = 1'b0;
        case (seq_q.st)
            ST_INIT: begin
                if (init_done_i) seq_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (ref_due) begin
                    seq_d.cmd  = CMD_REF;
                    seq_d.st   = ST_RFC;
                    wait_load  = 1'b1;
                    wait_value = LD_RFC;
                    ref_clear  = 1'b1;
                end else if (req_valid_i) begin
                    seq_d.cmd  = CMD_ACT;
                    seq_d.addr = req_row_i;
                    seq_d.ba   = req_bank_i;
                    seq_d.wr   = req_write_i;
                    seq_d.bank = req_bank_i;
                    seq_d.col  = req_col_i;
                    seq_d.st   = ST_RCD;
                    wait_load  = 1'b1;
                    wait_value = LD_RCD;
                end
            end
            ST_RCD: begin
                if (wait_zero) begin
                    seq_d.cmd  = seq_q.wr ? CMD_WR : CMD_RD;
                    seq_d.addr = seq_q.col;
                    seq_d.ba   = seq_q.bank;
                    seq_d.st   = ST_COL;
                end
            end
            ST_COL: begin
                seq_d.cmd  = CMD_PRE;
                seq_d.ba   = seq_q.bank;
                seq_d.st   = ST_RP;
                wait_load  = 1'b1;
                wait_value = LD_RP;
            end
            ST_RP: begin
                if (wait_zero) seq_d.st = ST_IDLE;
            end
            ST_RFC: begin
                if (wait_zero) seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_INIT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q      <= '0;
            seq_q.st   <= ST_INIT;
            seq_q.cmd  <= CMD_NOP;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign {cmd_csn_o, cmd_rasn_o, cmd_casn_o, cmd_wen_o} = pins;
    assign cmd_addr_o = seq_q.addr;
    assign cmd_bank_o = seq_q.ba;

    // ------------------------------------------------------------------
    // Pin-level protocol tracking for the assertions below
    // ------------------------------------------------------------------
    localparam int unsigned CHK_W = WAIT_W + 1;
    localparam logic [CHK_W-1:0] CHK_MAX = '1;

    logic              is_act, is_col, is_pre, is_ref;
    logic [CHK_W-1:0]  since_act_q, since_pre_q, since_ref_q;
    logic              open_q;
    logic [BANK_W-1:0] open_bank_q;

    assign is_act = (pins == PINS_ACT);
    assign is_col = (pins == PINS_RD) || (pins == PINS_WR);
    assign is_pre = (pins == PINS_PRE);
    assign is_ref = (pins == PINS_REF);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_act_q <= CHK_MAX;
            since_pre_q <= CHK_MAX;
            since_ref_q <= CHK_MAX;
            open_q      <= 1'b0;
            open_bank_q <= '0;
        end else begin
            since_act_q <= is_act ? CHK_W'(1) : (since_act_q == CHK_MAX ? CHK_MAX : since_act_q + 1'b1);
            since_pre_q <= is_pre ? CHK_W'(1) : (since_pre_q == CHK_MAX ? CHK_MAX : since_pre_q + 1'b1);
            since_ref_q <= is_ref ? CHK_W'(1) : (since_ref_q == CHK_MAX ? CHK_MAX : since_ref_q + 1'b1);
            if (is_act) begin
                open_q      <= 1'b1;
                open_bank_q <= cmd_bank_o;
            end else if (is_pre) begin
                open_q      <= 1'b0;
            end
        end
    end

    // R1: before initialization completes only NOPs appear and nothing is accepted
    p_init_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == ST_INIT) |-> (pins == PINS_NOP && !req_ready_o));

    // R3: column command exactly tRCD after the activate, to the open bank
    p_col_after_trcd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_col |-> (open_q && cmd_bank_o == open_bank_q && since_act_q == CHK_W'(TRCD_CYC)));

    // R4: a precharge always directly follows a column command
    p_pre_after_col_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_pre |-> $past(is_col));

    // R5, R7: activate only to a closed device, after tRP and tRFC
    p_act_gaps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_act |-> (!open_q && since_pre_q > CHK_W'(TRP_CYC)
                    && since_ref_q > CHK_W'(TRFC_CYC)));

    // R9: a refresh is only sent with every bank closed
    p_ref_closed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_ref |-> (!open_q && since_pre_q > CHK_W'(TRP_CYC)));

endmodule

// File: tb/memcmd_sequencer_bench.sv
module memcmd_sequencer_bench;

    localparam int unsigned CLK_PS   = 8000;
    localparam int unsigned REFI_PS  = 7812500;
    localparam int unsigned TRFC_PS  = 350000;
    localparam int          TRCD     = 2;
    localparam int          TRP      = 2;
    localparam int          REFI     = REFI_PS / CLK_PS;              // 976
    localparam int          TRFC     = (TRFC_PS + CLK_PS - 1) / CLK_PS; // 44

    localparam logic [3:0] NOP = 4'b1111;
    localparam logic [3:0] ACT = 4'b0011;
    localparam logic [3:0] RD  = 4'b0101;
    localparam logic [3:0] WR  = 4'b0100;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_done = 1'b0;
    logic        valid = 1'b0;
    logic        write = 1'b0;
    logic [2:0]  bank = '0;
    logic [15:0] row = '0;
    logic [15:0] col = '0;
    logic        ready;
    logic        csn, rasn, casn, wen;
    logic [15:0] addr;
    logic [2:0]  ba;
    logic [3:0]  pins;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    assign pins = {csn, rasn, casn, wen};

    always #4 clk = ~clk;
    always_ff @(posedge clk) cyc <= cyc + 1;

    memcmd_sequencer #(
        .CLK_PS   (CLK_PS),
        .REFI_PS  (REFI_PS),
        .TRFC_PS  (TRFC_PS),
        .TRCD_CYC (TRCD),
        .TRP_CYC  (TRP),
        .ADDR_W   (16),
        .BANK_W   (3)
    ) u_memcmd_sequencer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .init_done_i (init_done),
        .req_valid_i (valid),
        .req_write_i (write),
        .req_bank_i  (bank),
        .req_row_i   (row),
        .req_col_i   (col),
        .req_ready_o (ready),
        .cmd_csn_o   (csn),
        .cmd_rasn_o  (rasn),
        .cmd_casn_o  (casn),
        .cmd_wen_o   (wen),
        .cmd_addr_o  (addr),
        .cmd_bank_o  (ba)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_pins(input logic [3:0] p, input int limit, output int at);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (pins != p && n < limit);
        at = cyc;
        chk(pins == p, "wait for command (R6)", pins, p);
    endtask

    task automatic t_reset_init();
        valid = 1'b1; row = 16'h00AA; bank = 3'd1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!ready, "R1 ready low before init", ready, 0);
            chk(pins == NOP, "R1 NOP pins before init", pins, NOP);
            chk(addr == 0 && ba == 0, "R1 buses zero on NOP", {ba, addr}, 0);
        end
        valid = 1'b0;
        init_done = 1'b1;
        @(negedge clk);
        chk(ready, "R1 ready after init", ready, 1);
    endtask

    task automatic t_access(input bit wr, input logic [2:0] b, input logic [15:0] r, input logic [15:0] c);
        @(negedge clk);
        valid = 1'b1; write = wr; bank = b; row = r; col = c;
        while (!ready) @(negedge clk);
        @(negedge clk);
        valid = 1'b0;
        chk(pins == ACT && addr == r && ba == b, "R2 activate row/bank", {pins, ba, addr}, {ACT, b, r});
        for (int k = 1; k < TRCD; k++) begin
            @(negedge clk);
            chk(pins == NOP, "R3 NOP before column", pins, NOP);
        end
        @(negedge clk);
        chk(pins == (wr ? WR : RD) && addr == c && ba == b, "R3 column command",
            {pins, ba, addr}, {(wr ? WR : RD), b, c});
        @(negedge clk);
        chk(pins == PRE && addr == 0 && ba == b, "R4 precharge", {pins, ba, addr}, {PRE, b, 16'h0});
        for (int k = 1; k < TRP; k++) begin
            @(negedge clk);
            chk(!ready, "R5 ready low in tRP", ready, 0);
        end
        @(negedge clk);
        chk(ready, "R5 ready after tRP", ready, 1);
    endtask

    task automatic t_back_to_back();
        int p, a;
        @(negedge clk);
        valid = 1'b1; write = 1'b1; bank = 3'd3; row = 16'h0F0F; col = 16'h0010;
        wait_pins(PRE, 50, p);
        wait_pins(ACT, 50, a);
        valid = 1'b0;
        chk(a - p == TRP + 1, "R5 precharge to activate gap", a - p, TRP + 1);
        repeat (TRCD + TRP + 4) @(negedge clk);
    endtask

    task automatic t_refresh_and_priority();
        int r1, r2;
        wait_pins(REF, 3000, r1);
        chk(addr == 0 && ba == 0, "R6 refresh buses zero", {ba, addr}, 0);
        wait_pins(REF, 3000, r2);
        chk(r2 - r1 == REFI, "R6 refresh interval", r2 - r1, REFI);
        while (cyc != r2 + REFI - 1) @(negedge clk);
        valid = 1'b1; write = 1'b0; bank = 3'd6; row = 16'h7777; col = 16'h0004;
        chk(!ready, "R8 ready low when refresh due", ready, 0);
        @(negedge clk);
        chk(pins == REF, "R8 refresh before activate", pins, REF);
        chk(cyc - r2 == REFI, "R6 refresh on grid", cyc - r2, REFI);
        for (int k = 1; k < TRFC; k++) begin
            @(negedge clk);
            chk(!ready && pins == NOP, "R7 blocked during tRFC", {ready, pins}, {1'b0, NOP});
        end
        @(negedge clk);
        chk(ready, "R7 ready after tRFC", ready, 1);
        @(negedge clk);
        valid = 1'b0;
        chk(pins == ACT && row == addr, "R7 activate after tRFC", pins, ACT);
        repeat (TRCD + TRP + 4) @(negedge clk);
    endtask

    task automatic t_stream_across_refresh(input int grid);
        int last_pre = -1000;
        bit act_open = 1'b0;
        int rc = 0;
        int n = 0;
        @(negedge clk);
        valid = 1'b1; write = 1'b1; bank = 3'd7; row = 16'h1357; col = 16'h0200;
        while (pins != REF && n < 3000) begin
            @(negedge clk);
            n++;
            if (pins == ACT) act_open = 1'b1;
            if (pins == PRE) begin last_pre = cyc; act_open = 1'b0; end
        end
        rc = cyc;
        chk(pins == REF, "R9 refresh reached while streaming", pins, REF);
        chk(!act_open, "R9 access closed before refresh", act_open, 0);
        chk(rc - last_pre >= TRP + 1, "R9 refresh after tRP", rc - last_pre, TRP + 1);
        chk(rc >= grid && rc <= grid + TRCD + TRP + 2, "R9 refresh near its grid point", rc, grid);
        n = 0;
        while (pins != ACT && n < 200) begin
            @(negedge clk);
            n++;
        end
        valid = 1'b0;
        chk(cyc - rc == TRFC + 1, "R7 first activate after refresh", cyc - rc, TRFC + 1);
        repeat (TRCD + TRP + 4) @(negedge clk);
    endtask

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_init();
        wait_pins(REF, 3000, r0);
        repeat (TRFC + 2) @(negedge clk);
        t_access(1'b1, 3'd5, 16'h1234, 16'h00AB);
        t_access(1'b0, 3'd2, 16'hFFFF, 16'h03FF);
        t_back_to_back();
        t_refresh_and_priority();
        // previous refresh grid point is the one taken in the priority test
        t_stream_across_refresh(r0 + 4 * REFI);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule